// File: doc/BRIEF.md
# Phase-Accumulator SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a much faster reference clock. Instead of an integer divider, it uses a fractional phase accumulator. Every reference cycle a programmed increment is added to the accumulator. Each time the running sum passes a multiple of 1024, one half period of SCK ends. A full SCK period therefore spans 2048 accumulator counts. For a reference frequency f_ref and a wanted SCK frequency f_sck, software programs the increment as ceil(2048 / ceil(f_ref / f_sck)).

Alongside the SCK pin level, the block produces two strobes for the shift datapath. Each is one reference cycle wide: one tells the datapath to drive the next bit (launch), the other tells it to sample the incoming bit (latch). Further controls select:
- the idle level of SCK;
- which edge launches and which latches;
- whether the rate is doubled;
- whether the accumulator restarts from zero on every transfer loop;
- whether SCK is frozen while no slave select is active.

The block also reports when the programmed rate is too fast for synchronous capture of receive data, so the receive path can switch to its asynchronous input capture.

The transfer engine raises `run` for the duration of a transfer loop. It reads `launch_stb` and `latch_stb` in the same cycle that `sck` shows the matching edge.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is asserted, `sck` equals `cpol` and both strobes are low.
- R2: With `run` high and the clock not frozen, the accumulator adds the effective increment every cycle. Each time the sum reaches 1024 or more, 1024 is subtracted and `sck` toggles in the following cycle. From a zero accumulator, N running cycles with increment w yield floor(N*w/1024) edges.
- R3: When `dbl_rate` is 1, the effective increment is twice `freq_word`.
- R4: The effective increment saturates at 1024. Any larger request toggles `sck` on every running cycle.
- R5: An effective increment of 0 drives `sck` to its idle level and produces no strobes.
- R6: The idle level of `sck` is `cpol`. The running phase is XORed with `cpol` at the pin.
- R7: The leading edge is the edge that leaves the idle level; the trailing edge returns to it.
  - With `cpha` = 1, `launch_stb` marks leading edges and `latch_stb` marks trailing edges.
  - With `cpha` = 0, the roles are swapped.
- R8: Each strobe is one cycle wide. The two strobes are never high together. A strobe is high exactly in a cycle where `sck` has just changed.
- R9: While `gate_idle` = 1 and `ss_active` = 0, the accumulator and `sck` hold and no strobe fires. Counting resumes from the held phase afterwards.
- R10: While `run` = 0, `sck` is at its idle level and no strobe fires.
  - If `acc_clr_loop` = 1, the accumulator is cleared, so every loop starts from phase zero.
  - If `acc_clr_loop` = 0, the residue is kept for the next loop.
- R11: `async_capture` is 1 exactly when the effective increment exceeds floor(SYNC_MAX_HZ*2048/REF_HZ). With the defaults this limit is 307.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | FW_W (16) | Accumulator increment per reference cycle |
| dbl_rate | input | 1 | Doubles the increment |
| acc_clr_loop | input | 1 | Clear the accumulator between transfer loops |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 1: launch on leading edge; 0: latch on leading edge |
| gate_idle | input | 1 | Freeze SCK while no slave is selected |
| ss_active | input | 1 | A slave select is currently asserted |
| run | input | 1 | Transfer loop in progress |
| sck | output | 1 | Serial clock pin level |
| launch_stb | output | 1 | One-cycle strobe: drive next output bit |
| latch_stb | output | 1 | One-cycle strobe: sample input bit |
| async_capture | output | 1 | Rate requires asynchronous receive capture |

## Verification
Assertions placed in the RTL check, on every cycle:
- the strobes never overlap;
- every strobe coincides with an SCK change;
- a stopped loop leaves SCK idle;
- a zero increment stays quiet;
- a frozen clock holds its phase;
- the accumulator is cleared between loops;
- the increment never exceeds a half period.

Only the bench's scenarios can show:
- the long-run edge count for a given word;
- the effect of rate doubling and saturation;
- which strobe comes first for each phase setting;
- the difference between keeping and clearing the residue across loops.

The bench shows these by comparing against a behavioural model every cycle and by counting strobes over fixed windows.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

   // Kind of SCK transition produced in a cycle.
   typedef enum logic [1:0] {
      EDGE_NONE  = 2'd0,
      EDGE_LEAD  = 2'd1,
      EDGE_TRAIL = 2'd2
   } edge_kind_t;

   // Threshold increment above which synchronous capture is too slow.
   function automatic longint unsigned sync_word_limit(
      input longint unsigned ref_hz,
      input longint unsigned max_sync_hz,
      input longint unsigned full_counts
   );
      return (max_sync_hz * full_counts) / ref_hz;
   endfunction

endpackage

// File: rtl/spiclk_inc_scale.sv
module spiclk_inc_scale #(
   parameter int FW_W      = 16,
   parameter int HALF_LOG2 = 10,
   parameter bit ALLOW_2X  = 1'b1
) (
   input  logic [FW_W-1:0]      freq_word,
   input  logic                 dbl_rate,
   output logic [HALF_LOG2:0]   inc_eff,
   output logic                 inc_zero
);
   localparam int          INC_W    = HALF_LOG2 + 1;
   localparam int          SCALED_W = FW_W + 1;
   localparam logic [SCALED_W-1:0] HALF_EXT = SCALED_W'(1) << HALF_LOG2;

   logic [SCALED_W-1:0] scaled;

   generate
      if (ALLOW_2X) begin : g_dbl
         always_comb begin
            if (dbl_rate) scaled = {freq_word, 1'b0};
            else          scaled = {1'b0, freq_word};
         end
      end else begin : g_single
         logic unused_dbl;
         assign unused_dbl = dbl_rate;
         assign scaled     = {1'b0, freq_word};
      end
   endgenerate

   // Saturate to one half period so at most one edge occurs per cycle.
   always_comb begin
      if (scaled > HALF_EXT) inc_eff = HALF_EXT[INC_W-1:0];
      else                   inc_eff = scaled[INC_W-1:0];
   end

   assign inc_zero = (scaled == '0);

   generate
      if (FW_W < HALF_LOG2) begin : g_bad_fw
         $error("spiclk_inc_scale: FW_W must be at least HALF_LOG2");
      end
   endgenerate

endmodule

// File: rtl/spiclk_phase_acc.sv
module spiclk_phase_acc #(
   parameter int HALF_LOG2 = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               clr,
   input  logic [HALF_LOG2:0] inc,
   output logic               carry
);
   localparam int          SUM_W = HALF_LOG2 + 1;
   localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << HALF_LOG2;

   logic [HALF_LOG2-1:0] acc_q;
   logic [SUM_W-1:0]     sum;

   assign sum   = {1'b0, acc_q} + inc;
   assign carry = adv & sum[HALF_LOG2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (clr) acc_q <= '0;
      else if (adv) acc_q <= sum[HALF_LOG2-1:0];
   end

   assert_acc_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0));

   assert_inc_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inc <= HALF);

   assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(acc_q));

   generate
      if (HALF_LOG2 < 2) begin : g_bad_half
         $error("spiclk_phase_acc: HALF_LOG2 must be at least 2");
      end
   endgenerate

endmodule

// File: rtl/spiclk_edge_gen.sv
module spiclk_edge_gen
   import spiclk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic hold_idle,
   input  logic carry,
   input  logic cpol,
   input  logic cpha,
   output logic sck,
   output logic launch_stb,
   output logic latch_stb
);
   logic       phase_q;
   logic       phase_d;
   edge_kind_t kind;
   logic       launch_q;
   logic       latch_q;

   always_comb begin
      phase_d = phase_q;
      kind    = EDGE_NONE;
      if (hold_idle) begin
         phase_d = 1'b0;
      end else if (carry) begin
         phase_d = ~phase_q;
         kind    = phase_q ? EDGE_TRAIL : EDGE_LEAD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= 1'b0;
         launch_q <= 1'b0;
         latch_q  <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         launch_q <= (kind == EDGE_LEAD  &&  cpha) || (kind == EDGE_TRAIL && !cpha);
         latch_q  <= (kind == EDGE_LEAD  && !cpha) || (kind == EDGE_TRAIL &&  cpha);
      end
   end

   assign sck        = cpol ^ phase_q;
   assign launch_stb = launch_q;
   assign latch_stb  = latch_q;

   assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch_q && latch_q));

   assert_strobe_on_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_q || latch_q) |-> (phase_q != $past(phase_q)));

   assert_phase_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_idle && !carry) |=> ($stable(phase_q) && !launch_q && !latch_q));

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
   import spiclk_pkg::*;
#(
   parameter int FW_W        = 16,
   parameter int HALF_LOG2   = 10,
   parameter bit ALLOW_2X    = 1'b1,
   parameter int REF_HZ      = 200_000_000,
   parameter int SYNC_MAX_HZ = 30_000_000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FW_W-1:0] freq_word,
   input  logic            dbl_rate,
   input  logic            acc_clr_loop,
   input  logic            cpol,
   input  logic            cpha,
   input  logic            gate_idle,
   input  logic            ss_active,
   input  logic            run,
   output logic            sck,
   output logic            launch_stb,
   output logic            latch_stb,
   output logic            async_capture
);
   localparam int INC_W       = HALF_LOG2 + 1;
   localparam longint unsigned FULL_COUNTS = 64'(1) << (HALF_LOG2 + 1);
   localparam longint unsigned SYNC_WORD =
      sync_word_limit(64'(REF_HZ), 64'(SYNC_MAX_HZ), FULL_COUNTS);

   logic [INC_W-1:0] inc_eff;
   logic             inc_zero;
   logic             frozen;
   logic             adv;
   logic             clr;
   logic             hold_idle;
   logic             carry;

   spiclk_inc_scale #(
      .FW_W      (FW_W),
      .HALF_LOG2 (HALF_LOG2),
      .ALLOW_2X  (ALLOW_2X)
   ) u_scale (
      .freq_word (freq_word),
      .dbl_rate  (dbl_rate),
      .inc_eff   (inc_eff),
      .inc_zero  (inc_zero)
   );

   assign frozen    = gate_idle & ~ss_active;
   assign hold_idle = ~run | inc_zero;
   assign adv       = run & ~inc_zero & ~frozen;
   assign clr       = ~run & acc_clr_loop;

   spiclk_phase_acc #(
      .HALF_LOG2 (HALF_LOG2)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .clr   (clr),
      .inc   (inc_eff),
      .carry (carry)
   );

   spiclk_edge_gen u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_idle  (hold_idle),
      .carry      (carry),
      .cpol       (cpol),
      .cpha       (cpha),
      .sck        (sck),
      .launch_stb (launch_stb),
      .latch_stb  (latch_stb)
   );

   assign async_capture = (64'(inc_eff) > SYNC_WORD);

   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (sck == cpol && !launch_stb && !latch_stb));

   assert_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && freq_word == '0) |=> (sck == cpol && !launch_stb && !latch_stb));

   assert_gate_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && gate_idle && !ss_active) |=> (!launch_stb && !latch_stb));

   always_comb begin
      if (!rst_n) assert_reset_idle_R1: assert (!launch_stb && !latch_stb);
   end

   generate
      if (FW_W < 2) begin : g_bad_fw
         $error("spiclk_gen: FW_W too small");
      end
      if (REF_HZ <= 0 || SYNC_MAX_HZ <= 0) begin : g_bad_hz
         $error("spiclk_gen: frequencies must be positive");
      end
   endgenerate

endmodule

// File: tb/tb_spiclk_gen.sv
module tb_spiclk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 1024;
   localparam int SYNC_LIM   = 307;
   localparam int WD_CYCLES  = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] freq_word = '0;
   logic        dbl_rate = 1'b0;
   logic        acc_clr_loop = 1'b1;
   logic        cpol = 1'b0;
   logic        cpha = 1'b0;
   logic        gate_idle = 1'b0;
   logic        ss_active = 1'b1;
   logic        run = 1'b0;
   logic        sck, launch_stb, latch_stb, async_capture;

   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";
   int    n_launch = 0;
   int    n_latch = 0;
   bit    first_is_launch = 1'b0;
   bit    done = 1'b0;

   // reference model state
   int m_acc = 0;
   bit m_p = 1'b0;
   bit m_l = 1'b0;
   bit m_t = 1'b0;

   spiclk_gen dut (
      .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .dbl_rate(dbl_rate),
      .acc_clr_loop(acc_clr_loop), .cpol(cpol), .cpha(cpha),
      .gate_idle(gate_idle), .ss_active(ss_active), .run(run),
      .sck(sck), .launch_stb(launch_stb), .latch_stb(latch_stb),
      .async_capture(async_capture)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int eff_inc();
      int e;
      e = int'(freq_word) * (dbl_rate ? 2 : 1);
      if (e > HALF) e = HALF;
      return e;
   endfunction

   task automatic check(input string req, input int act, input int exp, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // model update at the edge, comparison a quarter period later
   always @(posedge clk) begin
      int e;
      e = eff_inc();
      if (!rst_n) begin
         m_acc = 0; m_p = 0; m_l = 0; m_t = 0;
      end else begin
         m_l = 0; m_t = 0;
         if (!run) begin
            m_p = 0;
            if (acc_clr_loop) m_acc = 0;
         end else if (e == 0) begin
            m_p = 0;
         end else if (gate_idle && !ss_active) begin
            // frozen
         end else begin
            m_acc = m_acc + e;
            if (m_acc >= HALF) begin
               m_acc = m_acc - HALF;
               m_p = !m_p;
               if (m_p == cpha) m_l = 1; else m_t = 1;
            end
         end
      end
      #(CLK_PERIOD/4);
      if (rst_n) begin
         check(cur_req, int'(sck), int'(cpol ^ m_p), "sck");
         check(cur_req, {launch_stb, latch_stb}, {m_l, m_t}, "strobes");
         check("R11", int'(async_capture), int'(eff_inc() > SYNC_LIM), "async_capture");
         check("R8", int'(launch_stb && latch_stb), 0, "overlap");
         if (launch_stb || latch_stb) begin
            if (n_launch + n_latch == 0) first_is_launch = launch_stb;
            if (launch_stb) n_launch++;
            if (latch_stb) n_latch++;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr_counts();
      n_launch = 0; n_latch = 0; first_is_launch = 0;
   endtask

   // run for n cycles from a cleared accumulator, then stop and count
   task automatic burst(input int n, input int exp_edges, input string req);
      acc_clr_loop = 1; run = 0; cyc(2);
      clr_counts();
      run = 1; cyc(n);
      run = 0; cyc(3);
      check(req, n_launch + n_latch, exp_edges, "edge count");
   endtask

   initial begin
      // R1 and R6: reset level follows cpol
      cur_req = "R1";
      #(CLK_PERIOD*2 + 1);
      check("R1", int'(sck), 0, "reset sck cpol=0");
      check("R1", int'(launch_stb | latch_stb), 0, "reset strobes");
      cpol = 1; #1;
      check("R6", int'(sck), 1, "reset sck idle high");
      cpol = 0;
      cyc(2);
      rst_n = 1;
      cyc(2);

      cur_req = "R2"; freq_word = 300;
      burst(400, (400*300)/1024, "R2");

      cur_req = "R3"; dbl_rate = 1;
      burst(200, (200*600)/1024, "R3");
      dbl_rate = 0;

      cur_req = "R4"; freq_word = 2000;
      burst(20, 20, "R4");
      freq_word = 700; dbl_rate = 1;
      burst(20, 20, "R4");
      dbl_rate = 0;

      cur_req = "R5"; freq_word = 0;
      burst(50, 0, "R5");
      check("R5", int'(sck), int'(cpol), "idle level with zero word");

      cur_req = "R6"; cpol = 1; freq_word = 512;
      burst(40, 20, "R6");
      check("R6", int'(sck), 1, "idle high after loop");

      cur_req = "R7"; cpol = 0; freq_word = 1024; cpha = 1;
      burst(10, 10, "R7");
      check("R7", int'(first_is_launch), 1, "cpha=1 first strobe launch");
      check("R7", n_launch, 5, "cpha=1 launch count");
      cpha = 0;
      burst(10, 10, "R7");
      check("R7", int'(first_is_launch), 0, "cpha=0 first strobe latch");
      check("R8", n_latch, 5, "cpha=0 latch count");

      // R9: freeze mid-loop, then resume
      cur_req = "R9"; freq_word = 400; acc_clr_loop = 1; run = 0; cyc(2);
      run = 1; cyc(7);
      clr_counts();
      gate_idle = 1; ss_active = 0; cyc(30);
      check("R9", n_launch + n_latch, 0, "no strobes while frozen");
      ss_active = 1; gate_idle = 0; cyc(10);
      run = 0; cyc(3);
      check("R9", n_launch + n_latch, (7*400 + 10*400)/1024 - (7*400)/1024, "resume from held phase");

      // R10: residue kept when not clearing
      cur_req = "R10"; freq_word = 300; acc_clr_loop = 1; run = 0; cyc(2);
      acc_clr_loop = 0;
      run = 1; cyc(5); run = 0; cyc(3);
      clr_counts();
      run = 1; cyc(2); run = 0; cyc(3);
      check("R10", n_launch + n_latch, 1, "residue kept across loops");
      check("R10", int'(sck), int'(cpol), "idle after stop");
      acc_clr_loop = 1; cyc(2);
      run = 1; cyc(5); run = 0; cyc(3);
      clr_counts();
      run = 1; cyc(2); run = 0; cyc(3);
      check("R10", n_launch + n_latch, 0, "cleared residue");

      // R11: synchronous capture limit
      cur_req = "R11";
      freq_word = 307; #1;
      check("R11", int'(async_capture), 0, "at limit");
      freq_word = 308; #1;
      check("R11", int'(async_capture), 1, "above limit");
      freq_word = 154; dbl_rate = 1; #1;
      check("R11", int'(async_capture), 1, "doubled above limit");
      dbl_rate = 0; #1;
      check("R11", int'(async_capture), 0, "undoubled below limit");
      cyc(3);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule